// File: doc/BRIEF.md
# Conditional Execution Evaluator

This block decides whether a conditional instruction runs. The decode stage presents a 4-bit condition code, and the block returns one pass bit on the next clock edge. The pass bit is computed from the arithmetic status flags, the loop-counter-expired signal, and a software selector. The arithmetic status flags are zero, negative, ALU overflow, ALU carry, multiplier overflow, shifter overflow and x-input sign.

Two of the codes defer to the software selector. The selector is a 4-bit register that the block holds. Software writes it to pick one of fourteen asynchronous flag pins, the x-input sign flag, or the shifter overflow flag. A selector write takes effect from the cycle after the write.

The flag pins come from outside the clock domain, so they pass through a two-flop synchronizer before they are used. All other inputs are used in the cycle they are presented.

Top module: `cond_eval_top`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, `cond_pass` is 0. Reset also sets the selector to 0, which selects flag pin 0.
- R2: Codes 0x0 to 0x5 test the result sign. 0x0 passes on zero. 0x1 passes on non-zero. 0x2 passes when the result is neither zero nor negative. 0x3 is the complement of 0x2. 0x4 passes on negative. 0x5 passes on non-negative.
- R3: Code 0x6 passes on ALU overflow and 0x7 on its absence. Code 0x8 passes on ALU carry and 0x9 on its absence. Code 0xC passes on multiplier overflow and 0xD on its absence.
- R4: Code 0xE passes while the loop counter has not expired. Code 0xF always passes.
- R5: Code 0xA passes when the selected software condition is true. Code 0xB passes when it is false.
- R6: The selected condition depends on the selector value. Values 0x0 to 0x7 choose flag pins 0 to 7, and values 0xA to 0xF choose flag pins 8 to 13; a chosen pin counts as true when it is high. Value 0x8 chooses the x-input sign flag and 0x9 chooses the shifter overflow flag.
- R7: A selector write is sampled on the clock edge. A test presented in the same cycle as the write still uses the old selector value. A test in the next cycle uses the new value.
- R8: A flag pin change captured at edge k first affects `cond_pass` after edge k+2.
- R9: `cond_pass` is registered. Its value after an edge reflects the code and the status flags present in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_code | input | 4 | Condition code under test |
| st_zero | input | 1 | Result-zero flag |
| st_neg | input | 1 | Result-negative flag |
| st_aovf | input | 1 | ALU overflow flag |
| st_carry | input | 1 | ALU carry flag |
| st_movf | input | 1 | Multiplier overflow flag |
| st_sovf | input | 1 | Shifter overflow flag |
| st_xsign | input | 1 | ALU x-input sign flag |
| cnt_expired | input | 1 | Loop counter expired |
| flag_pin | input | 14 | Asynchronous flag pins |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_data | input | 4 | Selector write value |
| cond_pass | output | 1 | Registered pass result |

## Verification
The hardest case to reach is a selector write and a software-condition test landing in the same cycle. In that case the result must come from the old selection even though the new value is already on the write port. To reach it, the stimulus first parks the selector on pin 8 with that pin low and pin 1 high. It then issues the write of 0x1 together with code 0xA. The expected result is a fail on that cycle and a pass on the next.

A second hard case is the synchronizer delay. It is exposed by holding code 0xA steady, raising a single selected pin, and checking the output edge by edge.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int CODE_W    = 4;
    localparam int SEL_W     = 4;
    localparam int PIN_CNT   = 14;
    localparam int SEL_SLOTS = 1 << SEL_W;
    localparam int LOW_PINS  = 8;
    localparam int XSIGN_IDX = 8;
    localparam int SOVF_IDX  = 9;
    localparam int SKIP      = 2;

    typedef enum logic [CODE_W-1:0] {
        CC_ZERO   = 4'h0,
        CC_NZERO  = 4'h1,
        CC_POS    = 4'h2,
        CC_NPOS   = 4'h3,
        CC_NEG    = 4'h4,
        CC_NNEG   = 4'h5,
        CC_AOVF   = 4'h6,
        CC_NAOVF  = 4'h7,
        CC_CARRY  = 4'h8,
        CC_NCARRY = 4'h9,
        CC_SW     = 4'hA,
        CC_NSW    = 4'hB,
        CC_MOVF   = 4'hC,
        CC_NMOVF  = 4'hD,
        CC_CNTRUN = 4'hE,
        CC_ALWAYS = 4'hF
    } cond_code_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic aovf;
        logic carry;
        logic movf;
        logic cnt_exp;
    } stat_flags_t;

    function automatic logic cond_resolve(cond_code_e code, stat_flags_t f, logic sw_hit);
        logic r;
        case (code)
            CC_ZERO:   r = f.zero;
            CC_NZERO:  r = !f.zero;
            CC_POS:    r = !f.zero && !f.neg;
            CC_NPOS:   r = f.zero || f.neg;
            CC_NEG:    r = f.neg;
            CC_NNEG:   r = !f.neg;
            CC_AOVF:   r = f.aovf;
            CC_NAOVF:  r = !f.aovf;
            CC_CARRY:  r = f.carry;
            CC_NCARRY: r = !f.carry;
            CC_SW:     r = sw_hit;
            CC_NSW:    r = !sw_hit;
            CC_MOVF:   r = f.movf;
            CC_NMOVF:  r = !f.movf;
            CC_CNTRUN: r = !f.cnt_exp;
            default:   r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 14,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync_o = stage_q[STAGES-1];

    // R8
    sync_first_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stage_q[0] == $past(pin_async));

endmodule

// File: rtl/sel_reg.sv
module sel_reg #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk) begin
        if (rst)        sel_q <= '0;
        else if (wr_en) sel_q <= wr_data;
    end

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel_q));

    // R7
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sel_q == $past(wr_data));

endmodule

// File: rtl/sw_cond_mux.sv
module sw_cond_mux
    import cond_eval_pkg::*;
#(
    parameter int PINS = PIN_CNT
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [PINS-1:0]  pin,
    input  logic             xsign,
    input  logic             sovf,
    output logic             hit
);
    logic [SEL_SLOTS-1:0] slot;

    generate
        for (genvar i = 0; i < SEL_SLOTS; i++) begin : g_slot
            if (i < LOW_PINS) begin : g_lo
                assign slot[i] = pin[i];
            end else if (i == XSIGN_IDX) begin : g_xs
                assign slot[i] = xsign;
            end else if (i == SOVF_IDX) begin : g_sv
                assign slot[i] = sovf;
            end else begin : g_hi
                assign slot[i] = pin[i-SKIP];
            end
        end
    endgenerate

    assign hit = slot[sel];

endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
    import cond_eval_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  cond_code,
    input  logic               st_zero,
    input  logic               st_neg,
    input  logic               st_aovf,
    input  logic               st_carry,
    input  logic               st_movf,
    input  logic               st_sovf,
    input  logic               st_xsign,
    input  logic               cnt_expired,
    input  logic [PIN_CNT-1:0] flag_pin,
    input  logic               sel_wr_en,
    input  logic [SEL_W-1:0]   sel_wr_data,
    output logic               cond_pass
);
    logic [PIN_CNT-1:0] pin_s;
    logic [SEL_W-1:0]   sel_cur;
    logic               sw_hit;
    stat_flags_t        flags;
    logic               pass_d;

    pin_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin_async(flag_pin), .pin_sync_o(pin_s)
    );

    sel_reg #(.SEL_W(SEL_W)) sel_i (
        .clk(clk), .rst(rst), .wr_en(sel_wr_en), .wr_data(sel_wr_data), .sel_q(sel_cur)
    );

    sw_cond_mux #(.PINS(PIN_CNT)) mux_i (
        .sel(sel_cur), .pin(pin_s), .xsign(st_xsign), .sovf(st_sovf), .hit(sw_hit)
    );

    always_comb begin
        flags.zero    = st_zero;
        flags.neg     = st_neg;
        flags.aovf    = st_aovf;
        flags.carry   = st_carry;
        flags.movf    = st_movf;
        flags.cnt_exp = cnt_expired;
        pass_d        = cond_resolve(cond_code_e'(cond_code), flags, sw_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) cond_pass <= 1'b0;
        else     cond_pass <= pass_d;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !cond_pass);

    // R4
    always_true_chk: assert property (@(posedge clk) disable iff (rst)
        cond_code == 4'hF |=> cond_pass);

    // R2
    zero_code_chk: assert property (@(posedge clk) disable iff (rst)
        cond_code == 4'h0 |=> cond_pass == $past(st_zero));

    // R3
    carry_code_chk: assert property (@(posedge clk) disable iff (rst)
        cond_code == 4'h8 |=> cond_pass == $past(st_carry));

    // R5
    sw_code_chk: assert property (@(posedge clk) disable iff (rst)
        cond_code == 4'hA |=> cond_pass == $past(sw_hit));

    // R5
    nsw_code_chk: assert property (@(posedge clk) disable iff (rst)
        cond_code == 4'hB |=> cond_pass == !$past(sw_hit));

endmodule

// File: tb/cond_eval_tb.sv
`timescale 1ns/1ps
module cond_eval_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cond_code;
    logic        st_zero, st_neg, st_aovf, st_carry, st_movf, st_sovf, st_xsign, cnt_expired;
    logic [13:0] flag_pin;
    logic        sel_wr_en;
    logic [3:0]  sel_wr_data;
    logic        cond_pass;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cond_eval_top dut_i (
        .clk(clk), .rst(rst), .cond_code(cond_code),
        .st_zero(st_zero), .st_neg(st_neg), .st_aovf(st_aovf), .st_carry(st_carry),
        .st_movf(st_movf), .st_sovf(st_sovf), .st_xsign(st_xsign),
        .cnt_expired(cnt_expired), .flag_pin(flag_pin),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data), .cond_pass(cond_pass)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: cond_pass=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic sel_model(logic [3:0] sel, logic [13:0] p, logic xs, logic sv);
        if (sel == 4'h8) return xs;
        if (sel == 4'h9) return sv;
        if (sel < 4'h8)  return p[sel];
        return p[sel - 4'd2];
    endfunction

    function automatic logic code_model(logic [3:0] c, logic z, logic n, logic av, logic ac,
                                        logic mv, logic ce, logic sw);
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return !(z || n);
            4'h3: return z || n;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return av;
            4'h7: return !av;
            4'h8: return ac;
            4'h9: return !ac;
            4'hA: return sw;
            4'hB: return !sw;
            4'hC: return mv;
            4'hD: return !mv;
            4'hE: return !ce;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string code_req(logic [3:0] c);
        if (c <= 4'h5) return "R2";
        if (c == 4'hE || c == 4'hF) return "R4";
        return "R3";
    endfunction

    task automatic write_sel(logic [3:0] v);
        sel_wr_en = 1'b1; sel_wr_data = v;
        step();
        sel_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cond_code = 4'hF;
        step(); step();
        check("R1", cond_pass, 1'b0);
        rst = 1'b0;
        step();
        check("R1", cond_pass, 1'b1);
        flag_pin = 14'h0001; cond_code = 4'hA;
        step(); step(); step();
        check("R1", cond_pass, 1'b1);
        flag_pin = 14'h3FFE;
        step(); step(); step();
        check("R1", cond_pass, 1'b0);
    endtask

    task automatic t_arith();
        flag_pin = 14'h0;
        for (int f = 0; f < 64; f++) begin
            for (int c = 0; c < 16; c++) begin
                if (c == 10 || c == 11) continue;
                {st_zero, st_neg, st_aovf, st_carry, st_movf, cnt_expired} = 6'(f);
                cond_code = 4'(c);
                step();
                check(code_req(4'(c)), cond_pass,
                      code_model(4'(c), st_zero, st_neg, st_aovf, st_carry, st_movf, cnt_expired, 1'b0));
            end
        end
        // R9: flag toggled one cycle after the code is still reflected from the presented cycle
        cond_code = 4'h0; st_zero = 1'b1;
        step();
        st_zero = 1'b0;
        check("R9", cond_pass, 1'b1);
        step();
        check("R9", cond_pass, 1'b0);
    endtask

    task automatic t_select();
        for (int s = 0; s < 16; s++) begin
            write_sel(4'(s));
            for (int p = 0; p < 2; p++) begin
                logic [13:0] pv;
                logic exp;
                int idx;
                idx = (s < 8) ? s : s - 2;
                pv = 14'h0;
                if (s != 8 && s != 9) pv[idx] = 1'b1;
                flag_pin = p[0] ? pv : ~pv;
                st_xsign = (s == 8) ? p[0] : !p[0];
                st_sovf  = (s == 9) ? p[0] : !p[0];
                step(); step();
                exp = sel_model(4'(s), flag_pin, st_xsign, st_sovf);
                cond_code = 4'hA;
                step();
                check("R6", cond_pass, exp);
                check("R5", cond_pass, p[0]);
                cond_code = 4'hB;
                step();
                check("R5", cond_pass, !exp);
            end
        end
    endtask

    task automatic t_latency();
        flag_pin = 14'h0002;
        write_sel(4'hA);
        step(); step();
        cond_code = 4'hA;
        sel_wr_en = 1'b1; sel_wr_data = 4'h1;
        step();
        sel_wr_en = 1'b0;
        check("R7", cond_pass, 1'b0);
        step();
        check("R7", cond_pass, 1'b1);
    endtask

    task automatic t_sync();
        flag_pin = 14'h0;
        write_sel(4'h0);
        cond_code = 4'hA;
        step(); step(); step();
        check("R8", cond_pass, 1'b0);
        flag_pin = 14'h0001;
        step();
        check("R8", cond_pass, 1'b0);
        step();
        check("R8", cond_pass, 1'b0);
        step();
        check("R8", cond_pass, 1'b1);
    endtask

    initial begin
        rst = 1'b1; cond_code = 4'h0; flag_pin = 14'h0;
        {st_zero, st_neg, st_aovf, st_carry, st_movf, st_sovf, st_xsign, cnt_expired} = 8'h0;
        sel_wr_en = 1'b0; sel_wr_data = 4'h0;
        t_reset();
        t_arith();
        t_select();
        t_latency();
        t_sync();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: cycles=%0d expected=finish", 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule